// File: doc/BRIEF.md
# Banked Data-Window Selector

This block sits on the data bus of a small 8-bit processor. It maps the lowest 64 bytes of the data address space, 00h to 3Fh, onto one of three physical pages: EEPROM page 0, EEPROM page 1 or RAM page 2. Each page is modelled here as a small internal array. Software picks the page by writing a byte to a select register at data address E8h. That register is write-only. A read of E8h returns 00h, and the register keeps its value through reset.

Only three bits of the select byte carry meaning: bit 0, bit 1 and bit 4. The block flags a byte with more than one of them set as a conflict. While a conflict stands, every page is shut off. The parameter `AVAIL_MASK` describes which pages a given build of the chip has. Selecting a page the build lacks raises an error output and reaches no storage. Every address outside the window, other than E8h, goes unchanged to an external pass-through port.

Top module: `bank_window_top`

## Requirements
- R1: A full-byte write (`cpu_wr` high, `cpu_bitop` low) to address E8h loads the select register at that clock edge. Window accesses in the next cycle use the new selection.
- R2: A read of address E8h returns 00h on `cpu_rdata`. Neither `ext_rd` nor `ext_wr` is asserted for it.
- R3: The select bits map to pages as follows: bit 0 selects EEPROM page 0, bit 1 selects EEPROM page 1, and bit 4 selects RAM page 2. An address in 00h to 3Fh accesses the selected page at offset equal to the address. Reads return data in the same cycle. Writes take effect at the clock edge.
- R4: Bits 7 to 5 and 3 to 2 of the select byte are ignored. With none of bits 0, 1 and 4 set, window reads return 00h and window writes change no page.
- R5: Reset changes neither the select register nor any page contents.
- R6: A write to E8h with `cpu_bitop` high is ignored and leaves the selection unchanged.
- R7: When two or more of bits 0, 1 and 4 are set, `sel_conflict` is high. Window reads return 00h, and window writes change no page.
- R8: When exactly one select bit is set and the matching `AVAIL_MASK` bit is 0, `sel_unavail` is high. In that state window reads return 00h and window writes change no page. `AVAIL_MASK` bit 0 covers EEPROM page 0, bit 1 covers EEPROM page 1, and bit 2 covers RAM page 2.
- R9: For an address of 40h or above, other than E8h, the block passes the address and write data to `ext_addr` and `ext_wdata` and raises `ext_rd` or `ext_wr` along with `cpu_rd` or `cpu_wr`. In that case `cpu_rdata` equals `ext_rdata` in the same cycle. Window and E8h accesses never strobe the external port.
- R10: `cpu_rdata` is 00h whenever `cpu_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not clear selection or pages) |
| cpu_addr | input | 8 | Data address from the processor |
| cpu_wdata | input | 8 | Write data from the processor |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_bitop | input | 1 | Marks the write as a single-bit set/clear operation |
| cpu_rdata | output | 8 | Read data to the processor |
| ext_addr | output | 8 | Address to the pass-through port |
| ext_wdata | output | 8 | Write data to the pass-through port |
| ext_wr | output | 1 | Pass-through write strobe |
| ext_rd | output | 1 | Pass-through read strobe |
| ext_rdata | input | 8 | Read data from the pass-through port |
| sel_conflict | output | 1 | More than one page selected |
| sel_unavail | output | 1 | Selected page absent in this build |

## Verification
The bench drives two instances from the same stimulus. The first has `AVAIL_MASK` = 3'b111, so all three pages exist. With it the bench can fill and read back every page, run conflict selections, test the ignored select bits, and check that contents survive reset. The second has `AVAIL_MASK` = 3'b100, which keeps only RAM page 2. There, selecting either EEPROM page raises `sel_unavail` and reads return 00h, while the RAM page in the same instance still returns the data shared with the first instance.

// File: rtl/bank_window_pkg.sv
package bank_window_pkg;

    localparam int NPAGES = 3;

    typedef enum logic [1:0] {
        PG_EE0  = 2'd0,
        PG_EE1  = 2'd1,
        PG_RAM2 = 2'd2
    } page_id_e;

    // Bit position inside the select byte that enables each page (by page id).
    localparam int SEL_BIT_POS [NPAGES] = '{0, 1, 4};

    typedef struct packed {
        logic is_win;   // address falls in the banked window
        logic is_sel;   // address is the select register
        logic is_ext;   // address goes to the pass-through port
    } route_t;

    typedef struct packed {
        logic [NPAGES-1:0] page_en;  // one-hot or zero
        logic              conflict;
        logic              unavail;
    } sel_state_t;

    function automatic int unsigned popcnt(input logic [NPAGES-1:0] v);
        int unsigned n = 0;
        for (int i = 0; i < NPAGES; i++) n += int'(v[i]);
        return n;
    endfunction

endpackage

// File: rtl/bank_addr_route.sv
module bank_addr_route
    import bank_window_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              WIN_DEPTH = 64,
    parameter logic [ADDR_W-1:0] SEL_ADDR = 8'hE8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              bitop,
    output route_t            route,
    output logic              sel_we,
    output logic              win_we,
    output logic              ext_we,
    output logic              ext_re
);
    localparam logic [ADDR_W:0] WIN_END = (ADDR_W+1)'(WIN_DEPTH);

    always_comb begin
        route.is_win = ({1'b0, addr} < WIN_END);
        route.is_sel = (addr == SEL_ADDR);
        route.is_ext = !route.is_win && !route.is_sel;
        sel_we = wr && route.is_sel && !bitop;
        win_we = wr && route.is_win;
        ext_we = wr && route.is_ext;
        ext_re = rd && route.is_ext;
    end
endmodule

// File: rtl/bank_select_reg.sv
module bank_select_reg
    import bank_window_pkg::*;
#(
    parameter logic [NPAGES-1:0] AVAIL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [NPAGES-1:0] wbits,
    output sel_state_t        state
);
    // Deliberately no reset: the selection outlives a reset.
    logic [NPAGES-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (we) sel_q <= wbits;
    end

    always_comb begin
        int unsigned n;
        n = popcnt(sel_q);
        state.conflict = (n > 1);
        state.unavail  = (n == 1) && |(sel_q & ~AVAIL_MASK);
        state.page_en  = (n == 1 && !state.unavail) ? sel_q : '0;
    end

    // R6 / R1: the selection only moves on a qualified write
    p_sel_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(sel_q));

    p_en_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(state.page_en));

    p_flag_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(state.conflict && state.unavail));
endmodule

// File: rtl/bank_page_array.sv
module bank_page_array #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/bank_window_top.sv
module bank_window_top
    import bank_window_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter int                WIN_DEPTH  = 64,
    parameter logic [ADDR_W-1:0] SEL_ADDR   = 8'hE8,
    parameter logic [NPAGES-1:0] AVAIL_MASK = 3'b111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              cpu_bitop,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              ext_wr,
    output logic              ext_rd,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              sel_conflict,
    output logic              sel_unavail
);
    localparam int IDX_W = $clog2(WIN_DEPTH);

    route_t            route;
    logic              sel_we, win_we, ext_we, ext_re;
    logic [NPAGES-1:0] sel_wbits;
    sel_state_t        sstate;
    logic [NPAGES-1:0] page_we;
    logic [DATA_W-1:0] page_rd [NPAGES];
    logic [DATA_W-1:0] win_rdata;
    logic [IDX_W-1:0]  win_idx;

    bank_addr_route #(
        .ADDR_W(ADDR_W), .WIN_DEPTH(WIN_DEPTH), .SEL_ADDR(SEL_ADDR)
    ) u_route (
        .addr(cpu_addr), .wr(cpu_wr), .rd(cpu_rd), .bitop(cpu_bitop),
        .route(route), .sel_we(sel_we), .win_we(win_we),
        .ext_we(ext_we), .ext_re(ext_re)
    );

    for (genvar g = 0; g < NPAGES; g++) begin : g_selbit
        assign sel_wbits[g] = cpu_wdata[SEL_BIT_POS[g]];
    end

    bank_select_reg #(.AVAIL_MASK(AVAIL_MASK)) u_sel (
        .clk(clk), .rst(rst), .we(sel_we), .wbits(sel_wbits), .state(sstate)
    );

    assign win_idx = cpu_addr[IDX_W-1:0];
    assign page_we = win_we ? sstate.page_en : '0;

    for (genvar g = 0; g < NPAGES; g++) begin : g_page
        if (AVAIL_MASK[g]) begin : g_present
            bank_page_array #(.DEPTH(WIN_DEPTH), .DATA_W(DATA_W)) u_arr (
                .clk(clk), .we(page_we[g]), .idx(win_idx),
                .wdata(cpu_wdata), .rdata(page_rd[g])
            );
        end else begin : g_absent
            assign page_rd[g] = '0;
        end
    end

    always_comb begin
        win_rdata = '0;
        for (int i = 0; i < NPAGES; i++)
            if (sstate.page_en[i]) win_rdata |= page_rd[i];
    end

    always_comb begin
        if (!cpu_rd)           cpu_rdata = '0;
        else if (route.is_win) cpu_rdata = win_rdata;
        else if (route.is_ext) cpu_rdata = ext_rdata;
        else                   cpu_rdata = '0;
    end

    assign ext_addr     = cpu_addr;
    assign ext_wdata    = cpu_wdata;
    assign ext_wr       = ext_we;
    assign ext_rd       = ext_re;
    assign sel_conflict = sstate.conflict;
    assign sel_unavail  = sstate.unavail;

    p_reg_rd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && cpu_addr == SEL_ADDR) |-> (cpu_rdata == '0));

    p_win_no_ext_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr < ADDR_W'(WIN_DEPTH)) |-> (!ext_wr && !ext_rd));

    p_conflict_block_r7: assert property (@(posedge clk) disable iff (rst)
        sel_conflict |-> (page_we == '0));

    p_unavail_block_r8: assert property (@(posedge clk) disable iff (rst)
        sel_unavail |-> (page_we == '0));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |-> (cpu_rdata == '0));

    p_bitop_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_bitop && cpu_addr == SEL_ADDR) |=> $stable(sstate));
endmodule

// File: tb/tb_bank_window_top.sv
`timescale 1ns/1ps
module tb_bank_window_top;
    logic       clk = 0;
    logic       rst = 0;
    logic [7:0] cpu_addr = 0, cpu_wdata = 0, ext_rdata = 0;
    logic       cpu_wr = 0, cpu_rd = 0, cpu_bitop = 0;
    logic [7:0] rd_f, rd_v, eaddr_f, ewd_f, eaddr_v, ewd_v;
    logic       ewr_f, erd_f, ewr_v, erd_v, cf_f, ua_f, cf_v, ua_v;

    always #2.5 clk = ~clk;

    bank_window_top #(.AVAIL_MASK(3'b111)) dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_bitop(cpu_bitop), .cpu_rdata(rd_f),
        .ext_addr(eaddr_f), .ext_wdata(ewd_f), .ext_wr(ewr_f), .ext_rd(erd_f),
        .ext_rdata(ext_rdata), .sel_conflict(cf_f), .sel_unavail(ua_f));

    bank_window_top #(.AVAIL_MASK(3'b100)) dut_v (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_bitop(cpu_bitop), .cpu_rdata(rd_v),
        .ext_addr(eaddr_v), .ext_wdata(ewd_v), .ext_wr(ewr_v), .ext_rd(erd_v),
        .ext_rdata(ext_rdata), .sel_conflict(cf_v), .sel_unavail(ua_v));

    int total = 0, fails = 0;
    bit sel_valid = 0;
    int m_sel = 0;
    int mem [3][64];

    task automatic chk(input string tag, input string note, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s): actual %0h expected %0h", tag, note, act, exp);
        end
    endtask

    // page index chosen by the model select byte, -1 none, -2 conflict
    function automatic int m_page();
        int n = int'(m_sel[0]) + int'(m_sel[1]) + int'(m_sel[4]);
        if (n == 0) return -1;
        if (n > 1)  return -2;
        if (m_sel[0]) return 0;
        if (m_sel[1]) return 1;
        return 2;
    endfunction

    function automatic int m_rdata(input int a, input bit r, input bit [2:0] avail);
        int p = m_page();
        if (!r) return 0;
        if (a == 8'hE8) return 0;
        if (a < 64) begin
            if (p < 0) return 0;
            if (!avail[p]) return 0;
            return mem[p][a];
        end
        return int'(ext_rdata);
    endfunction

    task automatic step(input int a, input int d, input bit w, input bit r,
                        input bit b, input string note);
        string tag;
        int p;
        bit wext, rext;
        @(negedge clk);
        cpu_addr = 8'(a); cpu_wdata = 8'(d); cpu_wr = w; cpu_rd = r; cpu_bitop = b;
        ext_rdata = 8'(a) ^ 8'h5A;
        #1;
        p = m_page();
        if (!r) tag = "R10";
        else if (a == 8'hE8) tag = "R2";
        else if (a >= 64) tag = "R9";
        else if (p == -1) tag = "R4";
        else if (p == -2) tag = "R7";
        else tag = "R3";
        if (a < 64 && !sel_valid) begin end
        else begin
            chk(tag, note, int'(rd_f), m_rdata(a, r, 3'b111));
            chk((a < 64 && p >= 0 && p < 2 && r) ? "R8" : tag, note,
                int'(rd_v), m_rdata(a, r, 3'b100));
        end
        wext = w && a >= 64 && a != 8'hE8;
        rext = r && a >= 64 && a != 8'hE8;
        chk("R9", note, int'(ewr_f), int'(wext));
        chk("R9", note, int'(erd_f), int'(rext));
        chk("R9", note, int'(erd_v), int'(rext));
        if (wext || rext) begin
            chk("R9", note, int'(eaddr_f), a);
            chk("R9", note, int'(ewd_f), d);
        end
        if (sel_valid) begin
            chk("R7", note, int'(cf_f), int'(p == -2));
            chk("R7", note, int'(cf_v), int'(p == -2));
            chk("R8", note, int'(ua_f), 0);
            chk("R8", note, int'(ua_v), int'(p == 0 || p == 1));
        end
        @(posedge clk);
        if (w && a == 8'hE8 && !b) begin
            m_sel = d; sel_valid = 1;
        end else if (w && a < 64 && p >= 0) begin
            mem[p][a] = d;
        end
    endtask

    task automatic sel(input int v, input string note);
        step(8'hE8, v, 1, 0, 0, note);
    endtask

    initial begin
        #(5.0 * 100000);
        $display("FAIL watchdog: actual running expected done");
        fails++; total++;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst = 1;
        for (int i = 0; i < 3; i++) step(8'h80, 0, 0, 0, 0, "reset idle R10");
        rst = 0;
        // pass-through port and register reads
        step(8'h40, 8'h11, 1, 0, 0, "ext write at 40h");
        step(8'h40, 0, 0, 1, 0, "ext read at 40h");
        step(8'hFF, 0, 0, 1, 0, "ext read at FFh");
        step(8'hE7, 8'h22, 1, 0, 0, "ext write at E7h");
        step(8'hE8, 0, 0, 1, 0, "select reg read R2");
        // fill every page (R1 selects, R3 writes)
        sel(8'h01, "R1 pick EE0");
        for (int i = 0; i < 64; i++) step(i, (i * 7 + 3) & 8'hFF, 1, 0, 0, "fill EE0");
        sel(8'h02, "R1 pick EE1");
        for (int i = 0; i < 64; i++) step(i, (i * 13 + 101) & 8'hFF, 1, 0, 0, "fill EE1");
        sel(8'h10, "R1 pick RAM2");
        for (int i = 0; i < 64; i++) step(i, (255 - i * 3) & 8'hFF, 1, 0, 0, "fill RAM2");
        step(8'h00, 0, 0, 1, 0, "RAM2 read 00h");
        step(8'h3F, 0, 0, 1, 0, "RAM2 read 3Fh");
        step(8'hE8, 0, 0, 1, 0, "read E8h stays zero R2");
        sel(8'h01, "R1 back to EE0");
        step(8'h00, 0, 0, 1, 0, "EE0 read 00h");
        step(8'h3F, 0, 0, 1, 0, "EE0 read 3Fh");
        sel(8'h02, "R1 EE1");
        step(8'h15, 0, 0, 1, 0, "EE1 read 15h");
        step(8'h15, 8'hC3, 1, 1, 0, "EE1 write+read same cycle");
        step(8'h15, 0, 0, 1, 0, "EE1 read after write R3");
        // unused select bits
        sel(8'h81, "R4 EE0 with bit7");
        step(8'h05, 0, 0, 1, 0, "R4 unused bit ignored");
        sel(8'h2C, "R4 only unused bits");
        step(8'h05, 0, 0, 1, 0, "R4 none reads zero");
        step(8'h05, 8'hEE, 1, 0, 0, "R4 none write dropped");
        sel(8'h01, "R4 reselect EE0");
        step(8'h05, 0, 0, 1, 0, "R4 EE0 untouched");
        // single-bit operations on the register
        step(8'hE8, 8'h10, 1, 0, 1, "R6 bitop ignored");
        step(8'h06, 0, 0, 1, 0, "R6 still EE0");
        // reset keeps selection and contents
        sel(8'h10, "R5 pick RAM2");
        rst = 1;
        step(8'h70, 0, 0, 0, 0, "R5 in reset");
        step(8'h70, 0, 0, 0, 0, "R5 in reset");
        rst = 0;
        step(8'h20, 0, 0, 1, 0, "R5 RAM2 survives reset");
        step(8'h3F, 0, 0, 1, 0, "R5 RAM2 survives reset");
        // conflicts
        sel(8'h03, "R7 EE0+EE1");
        step(8'h08, 0, 0, 1, 0, "R7 read zero");
        step(8'h08, 8'h99, 1, 0, 0, "R7 write blocked");
        sel(8'h11, "R7 EE0+RAM2");
        step(8'h08, 8'h77, 1, 1, 0, "R7 write blocked");
        sel(8'h13, "R7 all three");
        step(8'h09, 0, 0, 1, 0, "R7 read zero");
        sel(8'h01, "R7 back to EE0");
        step(8'h08, 0, 0, 1, 0, "R7 EE0 unchanged");
        sel(8'h10, "R7 RAM2");
        step(8'h08, 0, 0, 1, 0, "R7 RAM2 unchanged");
        // absent pages in the reduced build
        sel(8'h02, "R8 EE1 absent in variant");
        step(8'h30, 8'h5C, 1, 1, 0, "R8 write");
        step(8'h30, 0, 0, 1, 0, "R8 read");
        sel(8'h01, "R8 EE0 absent in variant");
        step(8'h31, 0, 0, 1, 0, "R8 read");
        sel(8'h10, "R8 RAM2 present");
        step(8'h31, 0, 0, 1, 0, "R8 variant RAM2 read");
        step(8'h31, 0, 0, 0, 0, "R10 idle");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule